// File: doc/BRIEF.md
# Multi-Pipe Receive Address Matcher

This block sits in a packet receive path, just after bit and byte alignment. It checks the address field at the head of each incoming packet against six receive pipes. For each packet it reports which enabled pipe, if any, owns the address. The address arrives one byte per cycle under a valid strobe, least significant byte first. A start marker comes with the first byte.

Pipe 0 has a complete private address of up to five bytes. Pipes 1 to 5 form a group: every member shares the same upper address bytes, and each has its own lowest byte. The first address byte therefore picks which group members are still candidates. The later bytes are all compared against the shared upper bytes. The address length in bytes is set by a small width code, and only that many bytes take part in the comparison.

One cycle after the last address byte, the block gives a single-cycle result strobe and a 3-bit pipe number. When no enabled pipe matches, the number is all ones. While each address byte is accepted, a strip flag is raised so that downstream logic drops the address bytes and keeps only the payload.

Top module: `rx_addr_match`

## Requirements
- R1: After reset, `match_vld` is 0 and `match_pipe` is 3'b111.
- R2: The address length follows `aw_code`: 2'b10 gives 4 bytes, 2'b11 gives 5 bytes, and 2'b01 or 2'b00 gives 3 bytes. Only bytes 0 to length-1 are compared.
- R3: Pipe 0 matches when address byte i equals `p0_addr[8i+7:8i]` for every compared byte i. Byte 0 is the least significant and arrives first.
- R4: Pipe k (k = 1 to 5) matches when byte 0 equals `grp_lo[8(k-1)+7:8(k-1)]` and every later compared byte i equals `grp_hi[8(i-1)+7:8(i-1)]`.
- R5: Pipe k can match only when `pipe_en[k]` is 1 in the cycle of the last address byte. A disabled pipe never matches.
- R6: When more than one enabled pipe matches, the lowest pipe number is reported.
- R7: When no enabled pipe matches, a result is still given, with `match_pipe` = 3'b111. The value 3'b110 never appears.
- R8: `match_vld` is a single-cycle pulse in the cycle after the last address byte is accepted. `match_pipe` changes only with that pulse and holds its value otherwise.
- R9: `addr_strip` is 1 in exactly the cycles in which an address byte is accepted. It is 0 for payload bytes, for idle cycles, and for bytes that arrive with no start marker outside an address.
- R10: A byte that carries `byte_sop` always starts a new address at byte 0. An address that was only partly received is dropped and gives no result.
- R11: Cycles with `byte_vld` low neither advance nor disturb an address in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_code | input | 2 | Address length code (see R2) |
| pipe_en | input | 6 | Enable bit for each pipe; bit k enables pipe k |
| p0_addr | input | 40 | Full private address of pipe 0, byte 0 in bits 7:0 |
| grp_hi | input | 32 | Upper address bytes shared by pipes 1 to 5 (address byte 1 in bits 7:0) |
| grp_lo | input | 40 | Low address bytes of pipes 1 to 5; pipe 1 in bits 7:0 |
| byte_vld | input | 1 | Byte strobe |
| byte_sop | input | 1 | Start marker; valid with the first address byte |
| byte_in | input | 8 | Incoming byte |
| addr_strip | output | 1 | The current byte belongs to the address and should be dropped |
| match_vld | output | 1 | Single-cycle result strobe |
| match_pipe | output | 3 | Number of the matching pipe, or 3'b111 when no pipe matches |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Pipe overlaps.** Pipe 0 is loaded with the same full address as a group pipe, and two group pipes are given the same low byte. A wrong priority would then report the higher pipe.
- **Enable bits.** Pipes are switched off one at a time. A design that ignores an enable bit would report that pipe instead of the next one or 3'b111.
- **Address length.** Every width code is used, including the unassigned one. Bytes just beyond the set length are left unsent, and bytes inside it are corrupted. A length decoded wrongly would shift the result pulse or accept a corrupted byte.
- **Stream disturbances.** Restarts in the middle of an address, idle gaps, and stray bytes without a start marker check that the byte counter realigns. A design that does not realign would strip payload, pulse at the wrong time, or give a result for an aborted address.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  localparam int NPIPE = 6;
  localparam int PID_W = 3;

  typedef logic [PID_W-1:0] pipe_id_t;

  localparam pipe_id_t NO_PIPE = 3'b111;

  // address length in bytes for a width code; the unassigned code acts as 3
  function automatic logic [2:0] aw_bytes(input logic [1:0] code);
    case (code)
      2'b10:   aw_bytes = 3'd4;
      2'b11:   aw_bytes = 3'd5;
      default: aw_bytes = 3'd3;
    endcase
  endfunction

  // lowest set bit of the hit vector wins; none set gives NO_PIPE
  function automatic pipe_id_t lowest_hit(input logic [NPIPE-1:0] hits);
    lowest_hit = NO_PIPE;
    for (int i = NPIPE - 1; i >= 0; i--) begin
      if (hits[i]) lowest_hit = pipe_id_t'(i);
    end
  endfunction

endpackage

// File: rtl/rxm_seq.sv
// Tracks where the stream is inside the address field.
module rxm_seq #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             byte_sop,
  input  logic [IDX_W-1:0] nbytes,
  output logic             take,
  output logic             first,
  output logic             last,
  output logic [IDX_W-1:0] idx_cur
);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign take    = byte_vld && (byte_sop || active_q);
  assign first   = take && byte_sop;
  assign idx_cur = byte_sop ? '0 : idx_q;
  assign last    = take && (idx_cur == nbytes - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (take) begin
      active_q <= !last;
      idx_q    <= idx_cur + IDX_W'(1);
    end
  end

endmodule

// File: rtl/rxm_p0_cmp.sv
// Running byte compare against the private address of pipe 0.
module rxm_p0_cmp #(
  parameter int BW    = 8,
  parameter int NB    = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [IDX_W-1:0] idx_cur,
  input  logic [BW-1:0]    byte_in,
  input  logic [NB*BW-1:0] addr,
  output logic             ok_next
);

  localparam int SLOTS = 1 << IDX_W;

  logic [BW-1:0] slot [SLOTS];
  logic          ok_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NB) begin : g_used
      assign slot[i] = addr[i*BW +: BW];
    end else begin : g_pad
      assign slot[i] = '0;
    end
  end

  assign ok_next = (first || ok_q) && (byte_in == slot[idx_cur]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ok_q <= 1'b0;
    else if (take) ok_q <= ok_next;
  end

endmodule

// File: rtl/rxm_grp_cmp.sv
// Pipes 1..5: low byte selects candidates, later bytes check the shared upper part.
module rxm_grp_cmp #(
  parameter int BW    = 8,
  parameter int NB    = 5,
  parameter int NGRP  = 5,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [IDX_W-1:0]     idx_cur,
  input  logic [BW-1:0]        byte_in,
  input  logic [NGRP*BW-1:0]   lo_bytes,
  input  logic [(NB-1)*BW-1:0] hi_bytes,
  output logic [NGRP-1:0]      hit_next
);

  localparam int SLOTS = 1 << IDX_W;

  logic [BW-1:0]   hi_slot [SLOTS];
  logic [NGRP-1:0] cand_q, cand_n, lo_eq;
  logic            up_q, up_n;
  logic [IDX_W-1:0] hi_idx;

  for (genvar i = 0; i < SLOTS; i++) begin : g_hi
    if (i < NB - 1) begin : g_used
      assign hi_slot[i] = hi_bytes[i*BW +: BW];
    end else begin : g_pad
      assign hi_slot[i] = '0;
    end
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_lo
    assign lo_eq[k] = (byte_in == lo_bytes[k*BW +: BW]);
  end

  assign hi_idx   = idx_cur - IDX_W'(1);
  assign cand_n   = first ? lo_eq : cand_q;
  assign up_n     = first ? 1'b1 : (up_q && (byte_in == hi_slot[hi_idx]));
  assign hit_next = cand_n & {NGRP{up_n}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      up_q   <= 1'b0;
    end else if (take) begin
      cand_q <= cand_n;
      up_q   <= up_n;
    end
  end

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
  import rxm_pkg::*;
#(
  parameter int BW = 8,
  parameter int NB = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               aw_code,
  input  logic [NPIPE-1:0]         pipe_en,
  input  logic [NB*BW-1:0]         p0_addr,
  input  logic [(NB-1)*BW-1:0]     grp_hi,
  input  logic [(NPIPE-1)*BW-1:0]  grp_lo,
  input  logic                     byte_vld,
  input  logic                     byte_sop,
  input  logic [BW-1:0]            byte_in,
  output logic                     addr_strip,
  output logic                     match_vld,
  output logic [PID_W-1:0]         match_pipe
);

  localparam int IDX_W = $clog2(NB) < 1 ? 1 : $clog2(NB);
  localparam int NGRP  = NPIPE - 1;

  logic [IDX_W-1:0] nbytes, idx_cur;
  logic             acc_take, acc_first, acc_last;
  logic             p0_hit;
  logic [NGRP-1:0]  grp_hit;
  logic [NPIPE-1:0] pipe_hits;

  assign nbytes = IDX_W'(aw_bytes(aw_code));

  rxm_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_vld(byte_vld),
    .byte_sop(byte_sop),
    .nbytes  (nbytes),
    .take    (acc_take),
    .first   (acc_first),
    .last    (acc_last),
    .idx_cur (idx_cur)
  );

  rxm_p0_cmp #(.BW(BW), .NB(NB), .IDX_W(IDX_W)) u_p0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (acc_take),
    .first  (acc_first),
    .idx_cur(idx_cur),
    .byte_in(byte_in),
    .addr   (p0_addr),
    .ok_next(p0_hit)
  );

  rxm_grp_cmp #(.BW(BW), .NB(NB), .NGRP(NGRP), .IDX_W(IDX_W)) u_grp (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (acc_take),
    .first   (acc_first),
    .idx_cur (idx_cur),
    .byte_in (byte_in),
    .lo_bytes(grp_lo),
    .hi_bytes(grp_hi),
    .hit_next(grp_hit)
  );

  assign pipe_hits  = {grp_hit, p0_hit} & pipe_en;
  assign addr_strip = acc_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vld  <= 1'b0;
      match_pipe <= NO_PIPE;
    end else begin
      match_vld <= acc_last;
      if (acc_last) match_pipe <= lowest_hit(pipe_hits);
    end
  end

endmodule

// File: rtl/rx_addr_match_chk.sv
module rx_addr_match_chk
  import rxm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic [NPIPE-1:0] pipe_en,
  input logic             addr_strip,
  input logic             match_vld,
  input logic [PID_W-1:0] match_pipe
);

  logic [NPIPE-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= pipe_en;
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |=> !match_vld);

  assert_pulse_after_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> $past(addr_strip));

  assert_pipe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_vld |-> $stable(match_pipe));

  assert_strip_needs_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strip |-> byte_vld);

  assert_enabled_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vld && match_pipe != NO_PIPE) |-> en_q[match_pipe]);

  assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_vld |-> (match_pipe != 3'b110));

endmodule

bind rx_addr_match rx_addr_match_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_vld  (byte_vld),
  .pipe_en   (pipe_en),
  .addr_strip(addr_strip),
  .match_vld (match_vld),
  .match_pipe(match_pipe)
);

// File: tb/sim_rx_addr_match.sv
module sim_rx_addr_match;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  aw_code = 2'b11;
  logic [5:0]  pipe_en = '0;
  logic [39:0] p0_addr = '0;
  logic [31:0] grp_hi = '0;
  logic [39:0] grp_lo = '0;
  logic        byte_vld = 1'b0;
  logic        byte_sop = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        addr_strip, match_vld;
  logic [2:0]  match_pipe;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] last_pipe = 3'b111;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_match u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    if (c == 2'b11) return 5;
    if (c == 2'b10) return 4;
    return 3;
  endfunction

  // expected owner, computed from whole-address comparisons
  function automatic logic [2:0] ref_pipe(input logic [39:0] a, input int nb);
    logic [39:0] mask, full;
    mask = (40'd1 << (8*nb)) - 40'd1;
    if (pipe_en[0] && ((a ^ p0_addr) & mask) == 0) return 3'd0;
    for (int k = 1; k <= 5; k++) begin
      full = {grp_hi, grp_lo[8*(k-1) +: 8]};
      if (pipe_en[k] && ((a ^ full) & mask) == 0) return 3'(k);
    end
    return 3'b111;
  endfunction

  // drive one byte at a falling edge, check strip now and result after the rising edge
  task automatic put_byte(input logic [7:0] b, input bit sop, input bit exp_strip,
                          input bit exp_pulse, input logic [2:0] exp_pipe, input string req);
    byte_vld = 1'b1; byte_sop = sop; byte_in = b;
    #1;
    check(addr_strip == exp_strip, "R9 strip", addr_strip, exp_strip);
    @(negedge clk);
    byte_vld = 1'b0; byte_sop = 1'b0;
    check(match_vld == exp_pulse, {req, " R8 pulse"}, match_vld, exp_pulse);
    if (exp_pulse) begin
      check(match_pipe == exp_pipe, {req, " pipe"}, match_pipe, exp_pipe);
      last_pipe = exp_pipe;
    end else begin
      check(match_pipe == last_pipe, "R8 hold", match_pipe, last_pipe);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b0;
      @(negedge clk);
      check(match_vld == 1'b0, "R11 idle pulse", match_vld, 0);
    end
  endtask

  task automatic send_pkt(input logic [39:0] a, input int npay, input bit gaps, input string req);
    int nb;
    logic [2:0] e;
    nb = len_of(aw_code);
    e = ref_pipe(a, nb);
    for (int i = 0; i < nb; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle(1 + $urandom % 2);
      put_byte(a[8*i +: 8], i == 0, 1'b1, i == nb - 1, e, req);
    end
    for (int i = 0; i < npay; i++) put_byte(8'($urandom), 1'b0, 1'b0, 1'b0, 3'b0, "R9 payload");
  endtask

  function automatic logic [39:0] grp_addr(input int k);
    return {grp_hi, grp_lo[8*(k-1) +: 8]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] a;
    int sel;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(match_vld == 1'b0, "R1 vld", match_vld, 0);
    check(match_pipe == 3'b111, "R1 pipe", match_pipe, 7);
    rst_n = 1'b1;
    @(negedge clk);

    p0_addr = 40'hA1_B2_C3_D4_E5;
    grp_hi  = 32'h11_22_33_44;
    grp_lo  = 40'h55_66_77_88_99;
    pipe_en = 6'b111111;

    // R3 pipe 0, full length
    aw_code = 2'b11;
    send_pkt(p0_addr, 2, 1'b0, "R3");
    check(last_pipe == 3'd0, "R3 direct", last_pipe, 0);
    // R4 each group pipe
    for (int k = 1; k <= 5; k++) send_pkt(grp_addr(k), 1, 1'b0, "R4");
    // R6 pipe 0 and pipe 2 share the full address
    p0_addr = grp_addr(2);
    send_pkt(grp_addr(2), 0, 1'b0, "R6");
    check(last_pipe == 3'd0, "R6 p0 wins", last_pipe, 0);
    // R5 disable pipe 0 -> pipe 2
    pipe_en = 6'b111110;
    send_pkt(grp_addr(2), 0, 1'b0, "R5");
    check(last_pipe == 3'd2, "R5 next pipe", last_pipe, 2);
    // R6 two group pipes with the same low byte
    grp_lo[8*3 +: 8] = grp_lo[8*1 +: 8];
    send_pkt(grp_addr(4), 0, 1'b0, "R6");
    check(last_pipe == 3'd2, "R6 lower group", last_pipe, 2);
    // R7 everything disabled
    pipe_en = 6'b000000;
    send_pkt(grp_addr(4), 0, 1'b0, "R7");
    check(last_pipe == 3'b111, "R7 none", last_pipe, 7);
    pipe_en = 6'b111111;
    // R2 width codes, top byte corrupted beyond the short lengths
    aw_code = 2'b00;
    a = p0_addr; a[39:24] = ~a[39:24];
    send_pkt(a, 1, 1'b0, "R2");
    check(last_pipe == 3'd0, "R2 len3", last_pipe, 0);
    aw_code = 2'b10;
    send_pkt(a, 1, 1'b0, "R2");
    aw_code = 2'b01;
    send_pkt(a, 1, 1'b0, "R2");
    // R10 restart after two bytes
    aw_code = 2'b11;
    put_byte(8'hEE, 1'b1, 1'b1, 1'b0, 3'b0, "R10");
    put_byte(8'hEE, 1'b0, 1'b1, 1'b0, 3'b0, "R10");
    send_pkt(grp_addr(5), 0, 1'b0, "R10");
    check(last_pipe == 3'd5, "R10 restart", last_pipe, 5);
    // R9 stray bytes without a start marker
    put_byte(8'h12, 1'b0, 1'b0, 1'b0, 3'b0, "R9 stray");
    put_byte(8'h34, 1'b0, 1'b0, 1'b0, 3'b0, "R9 stray");
    // R11 gaps inside an address
    send_pkt(p0_addr, 1, 1'b1, "R11");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        p0_addr = {8'($urandom), $urandom};
        grp_hi  = $urandom;
        grp_lo  = {8'($urandom), $urandom};
        pipe_en = 6'($urandom | $urandom);
        aw_code = 2'($urandom);
        if ($urandom % 3 == 0) grp_lo[8*($urandom % 5) +: 8] = grp_lo[7:0];
        if ($urandom % 3 == 0) p0_addr = grp_addr(1 + $urandom % 5);
      end
      sel = $urandom % 8;
      if (sel == 0) a = p0_addr;
      else if (sel <= 5) a = grp_addr(sel);
      else a = {8'($urandom), $urandom};
      if ($urandom % 6 == 0) a[8*($urandom % len_of(aw_code)) +: 8] ^= 8'(1 + $urandom % 255);
      if ($urandom % 10 == 0) begin
        put_byte(8'($urandom), 1'b1, 1'b1, 1'b0, 3'b0, "R10");
      end
      send_pkt(a, $urandom % 4, 1'b1, "R3/R4/R5/R6/R7");
      if ($urandom % 4 == 0) idle(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule